// File: doc/BRIEF.md
# Masked Prioritized Interrupt Router

This block gathers eight peripheral interrupt lines for a small processor. A mask decides which lines may interrupt. Software changes the mask through two write-only registers. Writing ones to the enable register turns those mask bits on. Writing ones to the disable register turns them off. Neither register needs a read-modify-write sequence, and zero bits in the written word leave their mask bits as they were.

Software reads a single read-only register to find out which line to service. It returns a small number for the winning line rather than a raw bit vector. Line 0 has the highest priority. The winner is reported as its index plus one, and zero means that no enabled line is pending. An interrupt service routine can use that number directly as a table index. The active-low request line to the processor is formed from the same masked vector that feeds the encoder. Priorities are fixed in hardware.

Top module: `irq_router`

## Requirements
- R1: While `rst` is high at a rising edge the mask becomes all zeros; after reset `irq_n` is high and a status read returns 0.
- R2: A write (`cs` and `wr_en` high) to address 0 sets every mask bit whose `wr_data` bit (bits 7:0 map to lines 7:0) is 1 and leaves every other mask bit unchanged, effective from the next cycle.
- R3: A write to address 1 clears every mask bit whose `wr_data` bit is 1 and leaves every other mask bit unchanged.
- R4: A read (`cs` and `rd_en` high) of address 2 places on `rd_data` in the next cycle the value k+1, where k is the lowest-numbered line with `src[k]` and mask bit k both 1; bits 15:4 of that value are 0.
- R5: A status read returns 0 when no line is both pending and enabled.
- R6: `irq_n` is low in the same cycle whenever some line is both pending and enabled, and high otherwise, following `src` without waiting for a clock edge.
- R7: Reads of addresses 0, 1 and 3 return 0, and writes to addresses 2 and 3 leave the mask unchanged.
- R8: Strobes while `cs` is low neither change the mask nor produce read data.
- R9: In any cycle after one with no read strobe, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for register access |
| addr | input | 2 | Register address: 0 enable, 1 disable, 2 status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after a read strobe |
| src | input | 8 | Interrupt request lines, active high |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The bench builds the block with the default parameters: eight lines, a 16-bit bus and a 2-bit address. At that size every line can be driven alone and in groups. This reaches both ends of the code range, 1 for line 0 and 8 for line 7, and confirms that the zero-extended upper status bits stay zero. With all lines pending, the bench moves the mask so that each priority step can be observed, and it also probes the unused address 3.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int SRC_N  = 8;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_ENABLE  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_DISABLE = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_STATUS  = 2'd2;

    typedef enum logic [1:0] {
        SEL_ENABLE,
        SEL_DISABLE,
        SEL_STATUS,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_op_t;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            ADR_ENABLE:  s = SEL_ENABLE;
            ADR_DISABLE: s = SEL_DISABLE;
            ADR_STATUS:  s = SEL_STATUS;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_router_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic [N-1:0] set_bits,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] mask
);

    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;
    logic [N-1:0] mask_nxt;

    always_comb begin
        set_v    = set_en ? set_bits : '0;
        clr_v    = clr_en ? clr_bits : '0;
        // the clear takes effect after the set when both fire together
        mask_nxt = (mask | set_v) & ~clr_v;
    end

    always_ff @(posedge clk) begin
        if (rst) mask <= '0;
        else     mask <= mask_nxt;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (mask == '0));

    a_r2_set_applies: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en) |=> ((mask & $past(set_bits)) == $past(set_bits)));

    a_r3_clear_applies: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((mask & $past(clr_bits)) == '0));

    a_r7_mask_holds: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(mask));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_router_pkg::*;
#(
    parameter int N      = SRC_N,
    localparam int CODE_W = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      src,
    input  logic [N-1:0]      mask,
    output logic [CODE_W-1:0] code,
    output logic              irq_n
);

    logic [N-1:0] masked;
    logic [N-1:0] seen;    // seen[i]: some line below i is active
    logic [N-1:0] grant;

    assign masked = src & mask;
    assign irq_n  = ~|masked;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chain
            if (gi == 0) begin : g_first
                assign seen[gi] = 1'b0;
            end else begin : g_rest
                assign seen[gi] = seen[gi-1] | masked[gi-1];
            end
            assign grant[gi] = masked[gi] & ~seen[gi];
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) code = code | CODE_W'(i + 1);
        end
    end

    logic [N-1:0] code_bit;
    assign code_bit = (code == '0) ? '0 : (N'(1) << (code - CODE_W'(1)));

    a_r4_code_is_active: assert property (@(posedge clk) disable iff (rst)
        (code != '0) |-> ((masked & code_bit) != '0));

    a_r4_nothing_higher: assert property (@(posedge clk) disable iff (rst)
        (code != '0) |-> ((masked & (code_bit - N'(1))) == '0));

    a_r5_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
        (code == '0) |-> irq_n);

endmodule

// File: rtl/irq_bus_if.sv
module irq_bus_if
    import irq_router_pkg::*;
#(
    parameter int N      = SRC_N,
    parameter int DW     = BUS_W,
    parameter int AW     = ADDR_W,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DW-1:0]     wr_data,
    input  logic [CODE_W-1:0] code,
    output logic              set_en,
    output logic              clr_en,
    output logic [N-1:0]      bits,
    output logic [DW-1:0]     rd_data
);

    bus_op_t op;

    always_comb begin
        op.wr  = cs & wr_en;
        op.rd  = cs & rd_en;
        op.sel = decode_addr(addr);
    end

    assign set_en = op.wr && (op.sel == SEL_ENABLE);
    assign clr_en = op.wr && (op.sel == SEL_DISABLE);
    assign bits   = wr_data[N-1:0];

    generate
        if (DW > N) begin : g_spare
            logic unused_hi_bits;
            assign unused_hi_bits = ^wr_data[DW-1:N];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (op.rd && op.sel == SEL_STATUS)
            rd_data <= DW'(code);
        else
            rd_data <= '0;
    end

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(cs && rd_en) |=> (rd_data == '0));

    a_r7_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (cs && rd_en && addr != ADR_STATUS) |=> (rd_data == '0));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N  = SRC_N,
    parameter int DW = BUS_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic [N-1:0]  src,
    output logic          irq_n
);

    localparam int CODE_W = $clog2(N + 1);

    logic              set_en;
    logic              clr_en;
    logic [N-1:0]      bits;
    logic [N-1:0]      mask;
    logic [CODE_W-1:0] code;

    irq_bus_if #(.N(N), .DW(DW), .AW(AW), .CODE_W(CODE_W)) u_bus (
        .clk(clk), .rst(rst), .cs(cs), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .code(code),
        .set_en(set_en), .clr_en(clr_en), .bits(bits), .rd_data(rd_data)
    );

    irq_mask_reg #(.N(N)) u_mask (
        .clk(clk), .rst(rst), .set_en(set_en), .set_bits(bits),
        .clr_en(clr_en), .clr_bits(bits), .mask(mask)
    );

    irq_prio_enc #(.N(N)) u_enc (
        .clk(clk), .rst(rst), .src(src), .mask(mask),
        .code(code), .irq_n(irq_n)
    );

    a_r6_request_matches_code: assert property (@(posedge clk) disable iff (rst)
        ((code != '0) == !irq_n));

    a_r8_no_select_no_change: assert property (@(posedge clk) disable iff (rst)
        !cs |=> $stable(mask));

endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs = 1'b0;
    logic [1:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [N-1:0]  src = '0;
    logic          irq_n;

    irq_router dut (
        .clk(clk), .rst(rst), .cs(cs), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .src(src), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    logic [N-1:0] mask_m = '0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];
    logic rd_seen = 1'b0;
    bit done = 1'b0;

    function automatic logic [DW-1:0] model_code(logic [N-1:0] s, logic [N-1:0] m);
        for (int i = 0; i < N; i++)
            if (s[i] && m[i]) return DW'(i + 1);
        return '0;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected status values as read data appears
    always @(posedge clk) rd_seen <= cs && rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0)
            check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end

    task automatic bus_write(logic [1:0] a, logic [DW-1:0] d, logic sel);
        @(negedge clk);
        cs = sel; addr = a; wr_en = 1'b1; wr_data = d;
        if (sel && a == 2'd0) mask_m = mask_m | d[N-1:0];
        if (sel && a == 2'd1) mask_m = mask_m & ~d[N-1:0];
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_read(logic [1:0] a, string req);
        @(negedge clk);
        cs = 1'b1; addr = a; rd_en = 1'b1;
        exp_q.push_back(a == 2'd2 ? model_code(src, mask_m) : '0);
        tag_q.push_back(req);
        @(negedge clk);
        cs = 1'b0; rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_irq(string req);
        #1;
        check(req, DW'(irq_n), DW'((src & mask_m) == '0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq_n after reset", DW'(irq_n), DW'(1));
        check("R9 idle read data", rd_data, '0);
        src = 8'hFF;
        bus_read(2'd2, "R1 status after reset");
        check_irq("R6 masked sources");
        // R2 enable lines 2 and 5
        bus_write(2'd0, 16'h0024, 1'b1);
        bus_read(2'd2, "R2 R4 status after enable");
        check_irq("R6 irq low");
        bus_write(2'd0, 16'h0001, 1'b1);
        bus_read(2'd2, "R4 line0 wins code1");
        // R3 clear line 0 only; line 2 stays
        bus_write(2'd1, 16'h0001, 1'b1);
        bus_read(2'd2, "R3 clear leaves others");
        src = 8'h20;
        check_irq("R6 combinational follow");
        bus_read(2'd2, "R4 line5 code6");
        bus_write(2'd0, 16'h0080, 1'b1);
        src = 8'h80;
        bus_read(2'd2, "R4 line7 code8");
        // R8 writes without cs ignored
        src = 8'h02;
        bus_write(2'd0, 16'h00FF, 1'b0);
        bus_read(2'd2, "R8 no cs no change");
        check_irq("R8 irq unchanged");
        // R7 writes to status and spare addresses ignored
        bus_write(2'd2, 16'h00FF, 1'b1);
        bus_write(2'd3, 16'h00FF, 1'b1);
        bus_read(2'd2, "R7 status write ignored");
        src = 8'hFF;
        bus_read(2'd0, "R7 enable reg reads zero");
        bus_read(2'd1, "R7 disable reg reads zero");
        bus_read(2'd3, "R7 spare reads zero");
        // R8 read without cs gives no data
        @(negedge clk);
        rd_en = 1'b1; addr = 2'd2;
        @(negedge clk);
        rd_en = 1'b0;
        check("R8 read without cs", rd_data, '0);
        // R5 clear everything
        bus_write(2'd1, 16'hFFFF, 1'b1);
        bus_read(2'd2, "R5 none enabled");
        check_irq("R5 irq high");
        // R1 reset mid-run
        bus_write(2'd0, 16'h0010, 1'b1);
        bus_read(2'd2, "R4 line4 code5");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; mask_m = '0;
        check_irq("R1 reset clears mask");
        bus_read(2'd2, "R1 status after second reset");
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check("R4 pending reads drained", DW'(exp_q.size()), '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule